// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit down-counting channel of a three-channel interval timer, together with the decoder for the shared control port. Software selects a channel and configures it by writing a control byte. It then loads the channel's count through a byte-wide data port, low byte first and high byte second. The count falls by one on every pulse of a tick enable (nominally 1.19318 MHz), and the channel stops when it reaches zero. The output goes high on expiry in the terminal-count interrupt mode. In the rate-generator and square-wave modes the output stays where it is.

Reads of the data port also alternate between the low and high bytes. They return either the live count or a snapshot frozen by a latch command. The snapshot is held until its high byte has been read. A control byte that asks for read-back, BCD counting, single-byte access or an unsupported mode is refused, and an error flag pulses for one cycle. The channel output also appears as a speaker bit in a port status byte.

Top module: `pit_channel`

## Requirements
- R1: After reset the count and snapshot are 0, both byte pointers point at the low byte, the channel is stopped, `outLevel` is 0, `portStatus` is 0x00 and `cfgErr` is 0.
- R2: Control byte layout: bits [7:6] select the channel (3 means read-back), bits [5:4] give the access type (00 latch, 11 low-then-high), bits [3:1] give the mode and bit 0 is BCD. A byte whose select field differs from `CHAN_ID` (and is not 3) leaves this channel unchanged and raises no error.
- R3: A control byte with select 3, or one addressed to this channel with access type 01 or 10, BCD set, or a mode other than 0, 2 or 3, sets `cfgErr` for exactly the following cycle and leaves the programmed mode unchanged.
- R4: A data write while the write pointer is at the low byte replaces bits [7:0] of the count, stops the countdown, forces `outLevel` to 0 in the next cycle and moves the pointer to the high byte.
- R5: A data write at the high byte replaces bits [15:8] and returns the pointer to the low byte. The countdown starts only if the resulting count is nonzero.
- R6: While running, the count drops by one on each cycle with `tickEn` high. When it reaches zero the channel stops, and it stays at zero without further ticks having any effect.
- R7: On expiry in mode 0 `outLevel` becomes 1 in the same cycle that the count becomes 0. In modes 2 and 3 `outLevel` is unchanged by expiry.
- R8: With no snapshot held, `rdData` shows the live count byte chosen by the read pointer. Each `dataRd` pulse toggles the pointer, low first.
- R9: A latch command (access type 00) while no snapshot is held copies the count and resets the read pointer to the low byte. Reads then return the snapshot until its high byte is read, which releases it. A latch command while a snapshot is held is ignored.
- R10: `portStatus` has bit `SPKR_POS` (default 5, value 0x20) equal to `outLevel`, and all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count-rate enable pulse |
| ctrlWr | input | 1 | Control-port write strobe |
| ctrlData | input | 8 | Control byte |
| dataWr | input | 1 | Data-port write strobe |
| dataRd | input | 1 | Data-port read strobe (advances the read pointer) |
| wrData | input | 8 | Data byte written |
| rdData | output | 8 | Byte a data read returns this cycle |
| outLevel | output | 1 | Channel output |
| portStatus | output | 8 | Status byte carrying the speaker bit |
| cfgErr | output | 1 | One-cycle pulse after a refused control byte |

## Verification
The checker watches on every cycle that the count falls by exactly one per tick while running and holds still while stopped. It also checks that a low-byte write always leaves the output low, that a rising output coincides with a zero count, and that a read-back select always flags an error. The bench scenarios cover what depends on history: the snapshot release after its high byte, an ignored second latch, the pointer reset a latch causes, a zero high-byte load that never starts, mode persistence across refused words, and the differing expiry behaviour of modes 0 and 2.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int BYTE_W = 8;

  // Access-type encodings in control bits [5:4]
  localparam logic [1:0] ACC_LATCH = 2'b00;
  localparam logic [1:0] ACC_WORD  = 2'b11;
  localparam logic [1:0] SEL_RDBK  = 2'b11;

  typedef struct packed {
    logic loadLo;     // write low byte, stop, drop output
    logic loadHi;     // write high byte, maybe start
    logic takeSnap;   // capture count into snapshot
    logic rdHi;       // read pointer at high byte
    logic useSnap;    // snapshot held
    logic modeIntTc;  // mode 0 selected
  } pitCtl_t;
endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int CHAN_ID = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [BYTE_W-1:0] ctrlData,
  input  logic              dataWr,
  input  logic              dataRd,
  output pitCtl_t           ctl,
  output logic              cfgErr
);
  localparam logic [1:0] MY_SEL = CHAN_ID[1:0];

  logic [1:0] selF, accF;
  logic [2:0] modeF;
  logic       bcdF;
  logic       forMe, isRdbk, isLatch, modeOk, badWord, doProgram, doSnap;
  logic [2:0] modeQ;
  logic       wrHi, rdHi, snapHeld, errQ;

  always_comb begin
    selF      = ctrlData[7:6];
    accF      = ctrlData[5:4];
    modeF     = ctrlData[3:1];
    bcdF      = ctrlData[0];
    isRdbk    = (selF == SEL_RDBK);
    forMe     = (selF == MY_SEL);
    isLatch   = (accF == ACC_LATCH);
    modeOk    = (modeF == 3'd0) || (modeF == 3'd2) || (modeF == 3'd3);
    badWord   = isRdbk || (forMe && !isLatch && ((accF != ACC_WORD) || bcdF || !modeOk));
    doProgram = ctrlWr && forMe && !isLatch && !badWord;
    doSnap    = ctrlWr && forMe && isLatch && !snapHeld;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= 3'd0;
      wrHi     <= 1'b0;
      rdHi     <= 1'b0;
      snapHeld <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      errQ <= ctrlWr && badWord;
      if (doProgram) modeQ <= modeF;
      if (dataWr) wrHi <= !wrHi;
      if (doSnap) begin
        snapHeld <= 1'b1;
        rdHi     <= 1'b0;
      end else if (dataRd) begin
        rdHi <= !rdHi;
        if (snapHeld && rdHi) snapHeld <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl.loadLo    = dataWr && !wrHi;
    ctl.loadHi    = dataWr && wrHi;
    ctl.takeSnap  = doSnap;
    ctl.rdHi      = rdHi;
    ctl.useSnap   = snapHeld;
    ctl.modeIntTc = (modeQ == 3'd0);
  end

  assign cfgErr = errQ;
endmodule

// File: rtl/pit_count.sv
module pit_count
  import pit_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [BYTE_W-1:0] wrByte,
  input  pitCtl_t           ctl,
  output logic [CW-1:0]     countVal,
  output logic              running,
  output logic              outLevel,
  output logic [BYTE_W-1:0] rdByte
);
  localparam int HW = CW - BYTE_W;

  logic [CW-1:0] countQ, snapQ, hiLoad, srcVal;
  logic          runQ, outQ;

  assign hiLoad = {wrByte[HW-1:0], countQ[BYTE_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      snapQ  <= '0;
      runQ   <= 1'b0;
      outQ   <= 1'b0;
    end else begin
      if (ctl.takeSnap) snapQ <= countQ;
      if (ctl.loadLo) begin
        countQ[BYTE_W-1:0] <= wrByte;
        runQ <= 1'b0;
        outQ <= 1'b0;
      end else if (ctl.loadHi) begin
        countQ <= hiLoad;
        runQ   <= (hiLoad != '0);
      end else if (runQ && tickEn) begin
        countQ <= countQ - 1'b1;
        if (countQ == CW'(1)) begin
          runQ <= 1'b0;
          if (ctl.modeIntTc) outQ <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    srcVal = ctl.useSnap ? snapQ : countQ;
    rdByte = '0;
    if (ctl.rdHi) rdByte[HW-1:0] = srcVal[CW-1:BYTE_W];
    else          rdByte = srcVal[BYTE_W-1:0];
  end

  assign countVal = countQ;
  assign running  = runQ;
  assign outLevel = outQ;
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CHAN_ID  = 2,
  parameter int CNT_W    = 16,
  parameter int SPKR_POS = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       ctrlWr,
  input  logic [7:0] ctrlData,
  input  logic       dataWr,
  input  logic       dataRd,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       outLevel,
  output logic [7:0] portStatus,
  output logic       cfgErr
);
  pitCtl_t          ctl;
  logic [CNT_W-1:0] countVal;
  logic             running;

  pit_ctrl #(.CHAN_ID(CHAN_ID)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .dataWr(dataWr), .dataRd(dataRd), .ctl(ctl), .cfgErr(cfgErr)
  );

  pit_count #(.CW(CNT_W)) u_count (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrByte(wrData), .ctl(ctl),
    .countVal(countVal), .running(running), .outLevel(outLevel), .rdByte(rdData)
  );

  always_comb begin
    portStatus = '0;
    portStatus[SPKR_POS] = outLevel;
  end
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          tickEn,
  input logic          ctrlWr,
  input logic [1:0]    ctrlSel,
  input logic          loadLo,
  input logic          loadHi,
  input logic          running,
  input logic [CW-1:0] countVal,
  input logic          outLevel,
  input logic          cfgErr
);
  // R6
  tick_decrement_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && tickEn && !loadLo && !loadHi) |=> (countVal == $past(countVal) - CW'(1)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !loadLo && !loadHi) |=> $stable(countVal));

  // R4
  low_write_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadLo |=> !outLevel);

  // R7
  rise_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outLevel) |-> (countVal == '0));

  // R3
  readback_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && ctrlSel == 2'b11) |=> cfgErr);
endmodule

bind pit_channel pit_channel_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .ctrlWr(ctrlWr),
  .ctrlSel(ctrlData[7:6]), .loadLo(ctl.loadLo), .loadHi(ctl.loadHi),
  .running(running), .countVal(countVal), .outLevel(outLevel), .cfgErr(cfgErr)
);

// File: tb/tb_pit_channel.sv
module tb_pit_channel;
  localparam int CLK_P = 10;

  logic       clk = 0, rstN = 0, tickEn = 0, ctrlWr = 0, dataWr = 0, dataRd = 0;
  logic [7:0] ctrlData = 0, wrData = 0;
  logic [7:0] rdData, portStatus;
  logic       outLevel, cfgErr;
  int         nRun = 0, nFail = 0;

  pit_channel dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .dataWr(dataWr), .dataRd(dataRd), .wrData(wrData), .rdData(rdData),
    .outLevel(outLevel), .portStatus(portStatus), .cfgErr(cfgErr)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int expCount(int n, int ticks);
    return (ticks >= n) ? 0 : n - ticks;
  endfunction

  function automatic logic expOut(int n, int ticks);
    return ticks >= n;
  endfunction

  task automatic ctlw(input logic [7:0] b);
    ctrlWr = 1; ctrlData = b; @(negedge clk); ctrlWr = 0;
  endtask

  task automatic wr(input logic [7:0] b);
    dataWr = 1; wrData = b; @(negedge clk); dataWr = 0;
  endtask

  task automatic rd(output logic [7:0] v);
    v = rdData; dataRd = 1; @(negedge clk); dataRd = 0;
  endtask

  task automatic rd16(output int v);
    logic [7:0] lo, hi;
    rd(lo); rd(hi); v = {hi, lo};
  endtask

  task automatic idle(input int n, input logic t);
    tickEn = t; repeat (n) @(negedge clk); tickEn = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    nRun++; nFail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int v, n, ticks;
    logic [7:0] b;
    logic t;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check(outLevel == 0, "R1 out", outLevel, 0);
    check(portStatus == 0, "R1 status", portStatus, 0);
    check(cfgErr == 0, "R1 err", cfgErr, 0);
    rd16(v); check(v == 0, "R1 count", v, 0);

    // R7 R10 mode 0 countdown of 5
    ctlw(8'hB0); check(cfgErr == 0, "R2 good word", cfgErr, 0);
    wr(8'h05); wr(8'h00);
    idle(4, 1); check(outLevel == 0, "R7 before expiry", outLevel, 0);
    idle(1, 1); check(outLevel == 1, "R7 at expiry", outLevel, 1);
    check(portStatus == 8'h20, "R10 speaker bit", portStatus, 8'h20);
    idle(3, 1); rd16(v); check(v == 0, "R6 stays zero", v, 0);

    // R4 low write stops and drops output
    ctlw(8'hB0); wr(8'h10); wr(8'h00); idle(3, 1);
    tickEn = 1; wr(8'h20);
    check(outLevel == 0, "R4 out low", outLevel, 0);
    idle(3, 1); rd16(v); check(v == 16'h0020, "R4 stopped", v, 16'h0020);
    wr(8'h00); idle(2, 1); rd16(v); check(v == 16'h001E, "R5 restart", v, 16'h001E);

    // R5 zero load never starts
    wr(8'h00); wr(8'h00); idle(5, 1);
    check(outLevel == 0, "R5 zero no expiry", outLevel, 0);
    rd16(v); check(v == 0, "R5 zero count", v, 0);

    // R3 refused words, mode kept
    ctlw(8'hB0);
    ctlw(8'hB2); check(cfgErr == 1, "R3 mode1", cfgErr, 1);
    @(negedge clk); check(cfgErr == 0, "R3 one-cycle pulse", cfgErr, 0);
    ctlw(8'hF0); check(cfgErr == 1, "R3 readback", cfgErr, 1);
    ctlw(8'h90); check(cfgErr == 1, "R3 single byte", cfgErr, 1);
    ctlw(8'hB1); check(cfgErr == 1, "R3 bcd", cfgErr, 1);
    ctlw(8'h34); check(cfgErr == 0, "R2 other channel", cfgErr, 0);
    wr(8'h02); wr(8'h00); idle(2, 1);
    check(outLevel == 1, "R3 R2 mode unchanged", outLevel, 1);

    // R7 mode 2 leaves output alone
    ctlw(8'hB4); wr(8'h03); wr(8'h00); idle(3, 1);
    check(outLevel == 0, "R7 mode2 out", outLevel, 0);
    rd16(v); check(v == 0, "R7 mode2 count", v, 0);

    // R9 latch snapshot
    ctlw(8'hB0); wr(8'h34); wr(8'h12);
    ctlw(8'h80); idle(5, 1);
    ctlw(8'h80);
    rd16(v); check(v == 16'h1234, "R9 snapshot", v, 16'h1234);
    rd16(v); check(v == 16'h122F, "R8 R9 released live", v, 16'h122F);
    rd(b); check(b == 8'h2F, "R8 live low", b, 8'h2F);
    ctlw(8'h80); idle(1, 1);
    rd16(v); check(v == 16'h122F, "R9 pointer reset", v, 16'h122F);
    rd16(v); check(v == 16'h122E, "R8 live after", v, 16'h122E);

    // R6 R7 random loads and tick patterns
    for (int i = 0; i < 20; i++) begin
      n = 1 + int'($urandom % 40);
      ctlw(8'hB0); wr(n[7:0]); wr(8'h00);
      ticks = 0;
      for (int c = 0; c < 60; c++) begin
        t = 1'($urandom % 2);
        tickEn = t; @(negedge clk); ticks += int'(t);
        check(outLevel == expOut(n, ticks), "R7 random out", outLevel, int'(expOut(n, ticks)));
      end
      tickEn = 0;
      rd16(v); check(v == expCount(n, ticks), "R6 random count", v, expCount(n, ticks));
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule